// File: doc/BRIEF.md
# Bipolar Coulomb Counting Accumulator

This block takes signed current readings from a delta-sigma converter that watches the voltage across a battery sense resistor. It subtracts a learned zero-current offset from each reading and adds the result to a signed net-charge total. Each reading is also steered by its sign. A reading above zero goes into an unsigned charge total. A reading below zero adds its magnitude to an unsigned discharge total. Two flags record the direction of the most recent reading that was accumulated. All three totals clamp at their limits and never wrap.

The offset is learned on request. A one-cycle trigger opens a calibration window. The next group of valid readings is summed and arithmetically shifted down, giving the floor of their mean, and that value is stored as the new offset. No readings are accumulated while the window is open. A clear input empties the totals and the flags but keeps the offset.

Top module: `coulomb_accum`

## Requirements
- R1: After a synchronous reset, `net_q`, `chg_q`, `dsg_q`, `chg_act`, `dsg_act` and `offset` are all zero, and no calibration window is open.
- R2: An accumulated reading has the corrected value c = smp_data − offset, with both operands taken as two's complement. `net_q` (two's complement, ACC_W bits) becomes net_q + c, clamped to the range [−2^(ACC_W−1), 2^(ACC_W−1)−1].
- R3: When c > 0, `chg_q` becomes chg_q + c, clamped at 2^ACC_W − 1. `chg_act` becomes 1, `dsg_act` becomes 0, and `dsg_q` does not change.
- R4: When c < 0, `dsg_q` becomes dsg_q + |c|, clamped at 2^ACC_W − 1. `dsg_act` becomes 1, `chg_act` becomes 0, and `chg_q` does not change.
- R5: When c = 0, `net_q`, `chg_q` and `dsg_q` do not change, and both activity flags become 0.
- R6: A `cal_start` pulse with no window open opens a window. A reading presented in that same cycle is still accumulated with the old offset. The next 2^CAL_LOG2 valid readings (16 by default) are summed, and `offset` becomes the floor of sum / 2^CAL_LOG2 in the cycle after the last of them. The window then closes.
- R7: While a window is open, valid readings leave `net_q`, `chg_q`, `dsg_q` and both flags unchanged, and a further `cal_start` is ignored.
- R8: `clr` zeroes `net_q`, `chg_q`, `dsg_q` and both flags on the next edge. It takes priority over a reading in the same cycle. It does not alter `offset` and does not stop an open window from counting readings.
- R9: In a cycle with `smp_vld` low, none of the outputs change, unless `clr` is asserted in that cycle.
- R10: Every output is registered. A reading presented with `smp_vld` at one rising edge is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Reading strobe |
| smp_data | input | SMP_W | Two's-complement converter reading |
| cal_start | input | 1 | Opens an offset-learning window |
| clr | input | 1 | Empties the totals and the flags |
| net_q | output | ACC_W | Signed net charge total |
| chg_q | output | ACC_W | Unsigned charge total |
| dsg_q | output | ACC_W | Unsigned discharge total |
| chg_act | output | 1 | Last accumulated reading was positive |
| dsg_act | output | 1 | Last accumulated reading was negative |
| offset | output | SMP_W | Learned offset, two's complement |

## Verification
The clamping limits are the hardest state to reach. With the default 40-bit totals, full-scale readings would need millions of cycles to hit them. The bench therefore builds the block with 20-bit totals and drives long runs of full-scale positive readings and then full-scale negative ones. This pins `net_q` at both signed limits and both unsigned totals at their ceiling. Offsets of both signs are learned first, including a negative sum that is not a multiple of 16, so the floor rounding and the corrected-zero case are also reached.

// File: rtl/coulomb_pkg.sv
package coulomb_pkg;
  typedef enum logic {
    CAL_IDLE = 1'b0,
    CAL_RUN  = 1'b1
  } cal_state_e;
endpackage

// File: rtl/coulomb_offset_cal.sv
module coulomb_offset_cal
  import coulomb_pkg::*;
#(
  parameter int SMP_W    = 16,
  parameter int CAL_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp,
  output logic             busy,
  output logic [SMP_W-1:0] offset
);
  localparam int SUM_W = SMP_W + CAL_LOG2;

  cal_state_e              st;
  logic [CAL_LOG2-1:0]     cnt;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] sum_nxt;
  logic signed [SUM_W-1:0] avg;

  // sign-extend the reading and add it to the window sum
  assign sum_nxt = sum + $signed({{CAL_LOG2{smp[SMP_W-1]}}, smp});
  // arithmetic shift gives the floor of the mean
  assign avg     = sum_nxt >>> CAL_LOG2;
  assign busy    = (st == CAL_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= CAL_IDLE;
      cnt    <= '0;
      sum    <= '0;
      offset <= '0;
    end else begin
      unique case (st)
        CAL_IDLE: begin
          if (start) begin
            st  <= CAL_RUN;
            cnt <= '0;
            sum <= '0;
          end
        end
        CAL_RUN: begin
          if (smp_vld) begin
            cnt <= cnt + 1'b1;
            sum <= sum_nxt;
            if (&cnt) begin
              offset <= avg[SMP_W-1:0];
              st     <= CAL_IDLE;
            end
          end
        end
        default: st <= CAL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coulomb_sat_acc.sv
module coulomb_sat_acc #(
  parameter int ACC_W      = 40,
  parameter int IN_W       = 17,
  parameter bit SIGNED_ACC = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [IN_W-1:0]  delta,
  output logic [ACC_W-1:0] acc
);
  localparam int EXT_W = ACC_W + 1 - IN_W;

  logic [ACC_W-1:0] nxt;

  generate
    if (SIGNED_ACC) begin : g_signed
      logic signed [ACC_W:0] ext_sum;
      logic                  ovf;
      assign ext_sum = $signed({acc[ACC_W-1], acc})
                     + $signed({{EXT_W{delta[IN_W-1]}}, delta});
      assign ovf     = ext_sum[ACC_W] ^ ext_sum[ACC_W-1];
      always_comb begin
        if (!ovf)
          nxt = ext_sum[ACC_W-1:0];
        else if (ext_sum[ACC_W])
          nxt = {1'b1, {(ACC_W-1){1'b0}}};
        else
          nxt = {1'b0, {(ACC_W-1){1'b1}}};
      end
    end else begin : g_unsigned
      logic [ACC_W:0] u_sum;
      assign u_sum = {1'b0, acc} + {{EXT_W{1'b0}}, delta};
      assign nxt   = u_sum[ACC_W] ? {ACC_W{1'b1}} : u_sum[ACC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)
      acc <= '0;
    else if (en)
      acc <= nxt;
  end
endmodule

// File: rtl/coulomb_accum.sv
module coulomb_accum #(
  parameter int SMP_W    = 16,
  parameter int ACC_W    = 40,
  parameter int CAL_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             cal_start,
  input  logic             clr,
  output logic [ACC_W-1:0] net_q,
  output logic [ACC_W-1:0] chg_q,
  output logic [ACC_W-1:0] dsg_q,
  output logic             chg_act,
  output logic             dsg_act,
  output logic [SMP_W-1:0] offset
);
  localparam int CORR_W = SMP_W + 1;

  logic              cal_busy;
  logic [CORR_W-1:0] corr;
  logic [CORR_W-1:0] mag;
  logic              is_pos;
  logic              is_neg;
  logic              acc_en;

  coulomb_offset_cal #(
    .SMP_W   (SMP_W),
    .CAL_LOG2(CAL_LOG2)
  ) u_cal (
    .clk    (clk),
    .rst    (rst),
    .start  (cal_start),
    .smp_vld(smp_vld),
    .smp    (smp_data),
    .busy   (cal_busy),
    .offset (offset)
  );

  // offset-corrected reading, one bit wider than the input
  assign corr   = {smp_data[SMP_W-1], smp_data} - {offset[SMP_W-1], offset};
  assign is_neg = corr[CORR_W-1];
  assign is_pos = !corr[CORR_W-1] && (|corr);
  assign mag    = is_neg ? (~corr + 1'b1) : corr;
  assign acc_en = smp_vld && !cal_busy && !clr;

  coulomb_sat_acc #(.ACC_W(ACC_W), .IN_W(CORR_W), .SIGNED_ACC(1'b1)) u_net (
    .clk(clk), .rst(rst), .clr(clr), .en(acc_en), .delta(corr), .acc(net_q)
  );

  coulomb_sat_acc #(.ACC_W(ACC_W), .IN_W(CORR_W), .SIGNED_ACC(1'b0)) u_chg (
    .clk(clk), .rst(rst), .clr(clr), .en(acc_en && is_pos), .delta(mag), .acc(chg_q)
  );

  coulomb_sat_acc #(.ACC_W(ACC_W), .IN_W(CORR_W), .SIGNED_ACC(1'b0)) u_dsg (
    .clk(clk), .rst(rst), .clr(clr), .en(acc_en && is_neg), .delta(mag), .acc(dsg_q)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      chg_act <= 1'b0;
      dsg_act <= 1'b0;
    end else if (acc_en) begin
      chg_act <= is_pos;
      dsg_act <= is_neg;
    end
  end
endmodule

// File: rtl/coulomb_accum_chk.sv
module coulomb_accum_chk #(
  parameter int SMP_W = 16,
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_vld,
  input logic             clr,
  input logic             cal_busy,
  input logic [ACC_W-1:0] net_q,
  input logic [ACC_W-1:0] chg_q,
  input logic [ACC_W-1:0] dsg_q,
  input logic             chg_act,
  input logic             dsg_act,
  input logic [SMP_W-1:0] offset
);
  // R3 R4: the direction flags never both claim activity
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(chg_act && dsg_act));

  // R3: charge total never falls except through clear
  p_chg_mono_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> chg_q >= $past(chg_q));

  // R4: discharge total never falls except through clear
  p_dsg_mono_r4: assert property (@(posedge clk) disable iff (rst)
    !clr |=> dsg_q >= $past(dsg_q));

  // R7: totals and flags hold while a window is open
  p_hold_cal_r7: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && !clr) |=> ($stable(net_q) && $stable(chg_q) && $stable(dsg_q)
                            && $stable(chg_act) && $stable(dsg_act)));

  // R8: clear empties totals and flags
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (net_q == '0 && chg_q == '0 && dsg_q == '0 && !chg_act && !dsg_act));

  // R6: offset moves only when a window completes
  p_off_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !cal_busy |=> $stable(offset));

  // R9: no strobe, no change
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld && !clr) |=> ($stable(net_q) && $stable(chg_q) && $stable(dsg_q)));
endmodule

bind coulomb_accum coulomb_accum_chk #(
  .SMP_W(SMP_W),
  .ACC_W(ACC_W)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .smp_vld (smp_vld),
  .clr     (clr),
  .cal_busy(cal_busy),
  .net_q   (net_q),
  .chg_q   (chg_q),
  .dsg_q   (dsg_q),
  .chg_act (chg_act),
  .dsg_act (dsg_act),
  .offset  (offset)
);

// File: tb/test_coulomb_accum.sv
module test_coulomb_accum;
  localparam int CLK_PERIOD = 10;
  localparam int SMP_W      = 16;
  localparam int ACC_W      = 20;
  localparam int CAL_N      = 16;
  localparam int WD_CYCLES  = 50000;

  localparam longint NET_MAX = (longint'(1) <<< (ACC_W - 1)) - 1;
  localparam longint NET_MIN = -(longint'(1) <<< (ACC_W - 1));
  localparam longint U_MAX   = (longint'(1) <<< ACC_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             smp_vld = 1'b0;
  logic [SMP_W-1:0] smp_data = '0;
  logic             cal_start = 1'b0;
  logic             clr = 1'b0;
  logic [ACC_W-1:0] net_q, chg_q, dsg_q;
  logic             chg_act, dsg_act;
  logic [SMP_W-1:0] offset;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model state
  longint m_net = 0, m_chg = 0, m_dsg = 0;
  bit     m_ca = 0, m_da = 0;
  int     m_off = 0;
  bit     m_busy = 0;
  int     m_cnt = 0;
  int     m_sum = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  coulomb_accum #(.SMP_W(SMP_W), .ACC_W(ACC_W), .CAL_LOG2(4)) i_coulomb_accum (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
    .cal_start(cal_start), .clr(clr), .net_q(net_q), .chg_q(chg_q),
    .dsg_q(dsg_q), .chg_act(chg_act), .dsg_act(dsg_act), .offset(offset)
  );

  function automatic longint clampl(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic compare(string tag);
    longint a_net, a_chg, a_dsg;
    int     a_off;
    a_net = longint'($signed(net_q));
    a_chg = longint'(chg_q);
    a_dsg = longint'(dsg_q);
    a_off = int'($signed(offset));
    n_cmp++;
    if (a_net !== m_net || a_chg !== m_chg || a_dsg !== m_dsg ||
        chg_act !== m_ca || dsg_act !== m_da || a_off !== m_off) begin
      n_bad++;
      $display("FAIL %s: net=%0d/%0d chg=%0d/%0d dsg=%0d/%0d ca=%0b/%0b da=%0b/%0b off=%0d/%0d (actual/expected)",
               tag, a_net, m_net, a_chg, m_chg, a_dsg, m_dsg,
               chg_act, m_ca, dsg_act, m_da, a_off, m_off);
    end
  endtask

  // drive one cycle at a falling edge, advance the model, compare at the next falling edge
  task automatic step(bit vld, int data, bit cal, bit clear, string tag);
    longint c;
    bit     acc;
    smp_vld   = vld;
    smp_data  = SMP_W'(data);
    cal_start = cal;
    clr       = clear;
    acc = vld && !m_busy && !clear;
    if (clear) begin
      m_net = 0; m_chg = 0; m_dsg = 0; m_ca = 0; m_da = 0;
    end else if (acc) begin
      c = longint'(data) - longint'(m_off);
      m_net = clampl(m_net + c, NET_MIN, NET_MAX);
      if (c > 0) begin
        m_chg = clampl(m_chg + c, 0, U_MAX); m_ca = 1; m_da = 0;
      end else if (c < 0) begin
        m_dsg = clampl(m_dsg - c, 0, U_MAX); m_ca = 0; m_da = 1;
      end else begin
        m_ca = 0; m_da = 0;
      end
    end
    if (m_busy) begin
      if (vld) begin
        m_sum += data;
        m_cnt++;
        if (m_cnt == CAL_N) begin
          m_off  = m_sum >>> 4;
          m_busy = 0;
        end
      end
    end else if (cal) begin
      m_busy = 1; m_cnt = 0; m_sum = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state");

    // plain accumulation with zero offset
    step(1, 1000, 0, 0, "R3 positive");
    step(1, 250, 0, 0, "R3 positive again");
    step(1, -700, 0, 0, "R4 negative");
    step(0, 5000, 0, 0, "R9 idle ignores data");
    step(1, 0, 0, 0, "R5 zero reading");
    step(1, -32768, 0, 0, "R2 full-scale negative");
    step(0, 0, 0, 0, "R10 hold");

    // calibration with positive readings; reading in trigger cycle still counts
    step(1, 300, 1, 0, "R6 trigger cycle accumulates");
    for (int i = 0; i < CAL_N; i++) begin
      if (i == 3) step(0, 999, 0, 0, "R7 idle inside window");
      if (i == 5) step(1, 90 + i, 1, 0, "R7 retrigger ignored");
      else if (i == 8) step(1, 90 + i, 0, 1, "R8 clear inside window");
      else step(1, 90 + i, 0, 0, "R7 reading absorbed");
    end
    step(1, 500, 0, 0, "R2 corrected by offset");
    step(1, m_off, 0, 0, "R5 corrected zero");
    step(1, m_off - 40, 0, 0, "R4 corrected negative");

    // negative offset with floor rounding: sum -17 -> -2
    step(0, 0, 1, 0, "R6 open window");
    for (int i = 0; i < CAL_N; i++)
      step(1, (i == 0) ? -2 : -1, 0, 0, "R6 negative window");
    step(1, -2, 0, 0, "R5 zero after negative offset");
    step(1, 10, 0, 0, "R3 after negative offset");

    // clear has priority over a reading, offset kept
    step(1, 1234, 0, 1, "R8 clear beats reading");

    // positive saturation
    for (int i = 0; i < 40; i++) step(1, 32767, 0, 0, "R3 clamp high");
    // negative saturation
    for (int i = 0; i < 80; i++) step(1, -32768, 0, 0, "R2 clamp low");
    step(1, 7, 0, 0, "R2 leave clamp");
    step(1, 0, 0, 1, "R8 clear after clamp");

    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      automatic int  d  = (i % 3 == 0) ? int'($signed(16'($urandom))) : (int'($urandom % 401) - 200);
      automatic bit  v  = ($urandom % 4) != 0;
      automatic bit  ca = ($urandom % 60) == 0;
      automatic bit  cl = ($urandom % 70) == 0;
      step(v, d, ca, cl, "R10 mixed traffic");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule